// File: doc/BRIEF.md
# Flag-Offset Register Port

This block keeps the two thresholds used by a FIFO's partial-status flags: the almost-empty threshold `n` and the almost-full threshold `m`. Each threshold is held as a low byte and a high part. The high part holds only the threshold bits above bit 7 that the FIFO address width needs. Software gets at these four slots without any address. A selector state machine moves to the next slot after each access, in a fixed cycle. It keeps its place when the load strobe is released, so a later burst continues where the last one stopped.

The port works only when the FIFO comes out of reset in load mode. The active-low load pin is sampled while reset is held, and low selects load mode. If the pin is high during reset, the load pin acts as a plain second write enable and this block stays idle. Writes take the 9-bit data input on the write clock. Reads put the selected slot on a registered 9-bit output on the read clock. The write side and the read side each have their own selector. The assembled `n` and `m` values feed the flag comparators outside this block.

Selector states are SLOT_N_LO, SLOT_N_HI, SLOT_M_LO and SLOT_M_HI. On each access of its own side, a selector takes the transition to the next state: N_LO to N_HI, N_HI to M_LO, M_LO to M_HI, and M_HI back to N_LO. With no access it holds its state, and reset puts it in SLOT_N_LO.

Top module: `ofs_port`

## Requirements
- R1: While reset is low, both thresholds return to 7, the read output returns to 0, the collision output returns to 0, and both selectors return to SLOT_N_LO.
- R2: In load mode, a write clock edge with `load_n`=0 and `wen1_n`=0 stores into the write selector's slot, and the selector then advances. The slot order is n low byte, n high part, m low byte, m high part, and it wraps after the fourth slot. A low-byte slot takes `din[7:0]` into threshold bits 7:0.
- R3: In load mode, with `load_n`=0 and `wen1_n`=1, neither threshold changes and the write selector does not advance.
- R4: With `load_n`=1, no slot is accessed: `wen1_n`=0 or a read request changes neither threshold, neither selector and not the read output.
- R5: After a partial burst followed by `load_n`=1, the next write access lands in the slot that follows the last slot written.
- R6: In load mode, a read clock edge with `load_n`, `ren1_n` and `ren2_n` all 0 loads the read selector's slot into `rd_data_o` and advances the read selector through the same cycle. If either read enable is 1, `rd_data_o` holds its value.
- R7: A high-part slot write stores `din` bits into threshold bits ADDR_W-1:8 only, and the other `din` bits are dropped. A high-part read returns threshold bits ADDR_W-1:8 in bits 0 upward, zero-extended. A low-byte read returns threshold bits 7:0 in bits 7:0, with bit 8 at 0. When ADDR_W is 8, the high part is empty: it reads as 0 and writes to it are ignored.
- R8: If `load_n` is 1 during reset, the port stays idle until the next reset. After that, `load_n`=0 with writes or reads leaves the thresholds at 7 and `rd_data_o` at 0.
- R9: When one read clock edge sees both a slot read and a slot write, `collide_o` is 1 for the following cycle. The read returns the pre-edge contents and the write still takes effect. `collide_o` is 0 after any edge without such an overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Synchronous active-low reset; mode is sampled while low |
| load_n | input | 1 | Active-low load strobe; its level during reset selects the mode |
| wen1_n | input | 1 | Active-low write enable |
| ren1_n | input | 1 | Active-low read enable 1 |
| ren2_n | input | 1 | Active-low read enable 2 |
| din | input | 9 | Write data |
| n_ofs_o | output | ADDR_W | Almost-empty threshold to the flag logic |
| m_ofs_o | output | ADDR_W | Almost-full threshold to the flag logic |
| rd_data_o | output | 9 | Registered readback of the selected slot |
| collide_o | output | 1 | Read and write slot access on the same read edge |

## Verification
The bench builds two copies side by side from one stimulus stream, with both clocks tied to one source. One copy uses ADDR_W=10, so the high part is two bits wide; a write of 0x1FF shows that the dropped data bits really are dropped. The other copy uses ADDR_W=8, where the high part is empty. That makes reachable the case of high-part writes being ignored and high-part reads returning zero. Since both clocks are one source, a collision is a single well-defined edge, and the pre-edge read value can be predicted exactly.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    typedef enum logic [1:0] {
        SLOT_N_LO = 2'd0,
        SLOT_N_HI = 2'd1,
        SLOT_M_LO = 2'd2,
        SLOT_M_HI = 2'd3
    } slot_e;

    function automatic slot_e slot_after(input slot_e s);
        slot_e r;
        unique case (s)
            SLOT_N_LO: r = SLOT_N_HI;
            SLOT_N_HI: r = SLOT_M_LO;
            SLOT_M_LO: r = SLOT_M_HI;
            SLOT_M_HI: r = SLOT_N_LO;
            default:   r = SLOT_N_LO;
        endcase
        return r;
    endfunction

    function automatic logic slot_is_hi(input slot_e s);
        return (s == SLOT_N_HI) || (s == SLOT_M_HI);
    endfunction

    function automatic logic slot_is_m(input slot_e s);
        return (s == SLOT_M_LO) || (s == SLOT_M_HI);
    endfunction

endpackage

// File: rtl/ofs_slot_fsm.sv
module ofs_slot_fsm
    import ofs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step_i,
    output slot_e slot_o
);

    slot_e state_q;
    slot_e state_d;

    // next-state process
    always_comb begin
        state_d = state_q;
        if (step_i) begin
            unique case (state_q)
                SLOT_N_LO: state_d = SLOT_N_HI;
                SLOT_N_HI: state_d = SLOT_M_LO;
                SLOT_M_LO: state_d = SLOT_M_HI;
                SLOT_M_HI: state_d = SLOT_N_LO;
                default:   state_d = SLOT_N_LO;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_N_LO;
        else        state_q <= state_d;
    end

    assign slot_o = state_q;

    assert_slot_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (state_q == slot_after($past(state_q))));

    assert_slot_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(state_q));

endmodule

// File: rtl/ofs_write_bank.sv
module ofs_write_bank
    import ofs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              wclk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              wen1_n,
    input  logic [8:0]        din,
    output logic [ADDR_W-1:0] n_o,
    output logic [ADDR_W-1:0] m_o
);

    localparam int              LO_W        = (ADDR_W < 8) ? ADDR_W : 8;
    localparam logic [ADDR_W-1:0] LO_MASK   = ADDR_W'((1 << LO_W) - 1);
    localparam logic [ADDR_W-1:0] OFS_RESET = ADDR_W'(7);

    logic              prog_mode_q;
    logic              wr_acc;
    slot_e             wslot;
    logic [ADDR_W-1:0] n_q, m_q;
    logic [ADDR_W-1:0] tgt, merged;

    assign wr_acc = prog_mode_q && !load_n && !wen1_n;

    ofs_slot_fsm u_wsel (
        .clk    (wclk),
        .rst_n  (rst_n),
        .step_i (wr_acc),
        .slot_o (wslot)
    );

    always_ff @(posedge wclk) begin
        if (!rst_n) prog_mode_q <= !load_n;
    end

    always_comb begin
        tgt = slot_is_m(wslot) ? m_q : n_q;
        if (slot_is_hi(wslot))
            merged = (tgt & LO_MASK) | (ADDR_W'({din, 8'h00}) & ~LO_MASK);
        else
            merged = (tgt & ~LO_MASK) | (ADDR_W'(din[7:0]) & LO_MASK);
    end

    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            n_q <= OFS_RESET;
            m_q <= OFS_RESET;
        end else if (wr_acc) begin
            if (slot_is_m(wslot)) m_q <= merged;
            else                  n_q <= merged;
        end
    end

    assign n_o = n_q;
    assign m_o = m_q;

    assert_idle_keeps_R3: assert property (@(posedge wclk) disable iff (!rst_n)
        !wr_acc |=> ($stable(n_q) && $stable(m_q)));

    assert_mode_locked_R8: assert property (@(posedge wclk) disable iff (!rst_n)
        rst_n |=> $stable(prog_mode_q));

    assert_one_side_written_R2: assert property (@(posedge wclk) disable iff (!rst_n)
        wr_acc |=> ($stable(n_q) || $stable(m_q)));

endmodule

// File: rtl/ofs_read_port.sv
module ofs_read_port
    import ofs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              ren1_n,
    input  logic              ren2_n,
    input  logic              wen1_n,
    input  logic [ADDR_W-1:0] n_i,
    input  logic [ADDR_W-1:0] m_i,
    output logic [8:0]        rd_data_o,
    output logic              collide_o
);

    localparam int                LO_W    = (ADDR_W < 8) ? ADDR_W : 8;
    localparam logic [ADDR_W-1:0] LO_MASK = ADDR_W'((1 << LO_W) - 1);

    logic              prog_mode_q;
    logic              rd_strobe;
    slot_e             rslot;
    logic [ADDR_W-1:0] src;
    logic [8:0]        view;
    logic [8:0]        rd_q;
    logic              col_q;

    assign rd_strobe = prog_mode_q && !load_n && !ren1_n && !ren2_n;

    ofs_slot_fsm u_rsel (
        .clk    (rclk),
        .rst_n  (rst_n),
        .step_i (rd_strobe),
        .slot_o (rslot)
    );

    always_ff @(posedge rclk) begin
        if (!rst_n) prog_mode_q <= !load_n;
    end

    always_comb begin
        src = slot_is_m(rslot) ? m_i : n_i;
        if (slot_is_hi(rslot)) view = 9'(src >> 8);
        else                   view = 9'(src & LO_MASK);
    end

    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            col_q <= 1'b0;
        end else begin
            col_q <= rd_strobe && !wen1_n;
            if (rd_strobe) rd_q <= view;
        end
    end

    assign rd_data_o = rd_q;
    assign collide_o = col_q;

    assert_rd_hold_R6: assert property (@(posedge rclk) disable iff (!rst_n)
        !rd_strobe |=> $stable(rd_q));

    assert_collide_cause_R9: assert property (@(posedge rclk) disable iff (!rst_n)
        col_q |-> $past(rd_strobe));

    assert_top_bit_zero_R7: assert property (@(posedge rclk) disable iff (!rst_n)
        (ADDR_W <= 16) |-> !rd_q[8]);

endmodule

// File: rtl/ofs_port.sv
module ofs_port #(
    parameter int ADDR_W = 10
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              wen1_n,
    input  logic              ren1_n,
    input  logic              ren2_n,
    input  logic [8:0]        din,
    output logic [ADDR_W-1:0] n_ofs_o,
    output logic [ADDR_W-1:0] m_ofs_o,
    output logic [8:0]        rd_data_o,
    output logic              collide_o
);

    logic [ADDR_W-1:0] n_w, m_w;

    ofs_write_bank #(.ADDR_W(ADDR_W)) u_wbank (
        .wclk   (wclk),
        .rst_n  (rst_n),
        .load_n (load_n),
        .wen1_n (wen1_n),
        .din    (din),
        .n_o    (n_w),
        .m_o    (m_w)
    );

    ofs_read_port #(.ADDR_W(ADDR_W)) u_rport (
        .rclk      (rclk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .ren1_n    (ren1_n),
        .ren2_n    (ren2_n),
        .wen1_n    (wen1_n),
        .n_i       (n_w),
        .m_i       (m_w),
        .rd_data_o (rd_data_o),
        .collide_o (collide_o)
    );

    assign n_ofs_o = n_w;
    assign m_ofs_o = m_w;

endmodule

// File: tb/ofs_port_test.sv
module ofs_port_test;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n, ld_n, wen_n, ren1_n, ren2_n;
    logic [8:0] din;

    logic [9:0] n10, m10;
    logic [7:0] n8, m8;
    logic [8:0] rd10, rd8;
    logic       col10, col8;

    ofs_port #(.ADDR_W(10)) uut (
        .wclk(clk), .rclk(clk), .rst_n(rst_n), .load_n(ld_n), .wen1_n(wen_n),
        .ren1_n(ren1_n), .ren2_n(ren2_n), .din(din),
        .n_ofs_o(n10), .m_ofs_o(m10), .rd_data_o(rd10), .collide_o(col10));

    ofs_port #(.ADDR_W(8)) uut8 (
        .wclk(clk), .rclk(clk), .rst_n(rst_n), .load_n(ld_n), .wen1_n(wen_n),
        .ren1_n(ren1_n), .ren2_n(ren2_n), .din(din),
        .n_ofs_o(n8), .m_ofs_o(m8), .rd_data_o(rd8), .collide_o(col8));

    int checks = 0;
    int fails  = 0;

    logic [15:0] e_n [2];
    logic [15:0] e_m [2];
    logic [8:0]  e_rd [2];
    logic        e_col;
    logic [1:0]  wsel, rsel;
    logic        mode;

    function automatic logic [15:0] full_mask(input int aw);
        return 16'((32'd1 << aw) - 1);
    endfunction

    function automatic logic [15:0] low_mask(input int aw);
        return (aw < 8) ? full_mask(aw) : 16'h00FF;
    endfunction

    function automatic logic [15:0] wr_model(input logic [15:0] v, input logic [1:0] s,
                                             input logic [8:0] d, input int aw);
        logic [15:0] lo = low_mask(aw);
        if (!s[0]) return (v & ~lo) | ({8'h00, d[7:0]} & lo);
        return (v & lo) | ({d[7:0], 8'h00} & full_mask(aw) & ~lo);
    endfunction

    function automatic logic [8:0] rd_model(input logic [15:0] v, input logic [1:0] s, input int aw);
        if (!s[0]) return 9'(v & low_mask(aw));
        return 9'(v >> 8);
    endfunction

    task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // apply current inputs to the model, pass one clock edge, compare
    task automatic cycle(input string req);
        logic rs, ws;
        if (!rst_n) begin
            mode = !ld_n;
            for (int i = 0; i < 2; i++) begin
                e_n[i] = 16'd7; e_m[i] = 16'd7; e_rd[i] = 9'd0;
            end
            wsel = 2'd0; rsel = 2'd0; e_col = 1'b0;
        end else begin
            rs = mode && !ld_n && !ren1_n && !ren2_n;
            ws = mode && !ld_n && !wen_n;
            e_col = rs && ws;
            for (int i = 0; i < 2; i++) begin
                int aw = (i == 0) ? 10 : 8;
                if (rs) e_rd[i] = rd_model(rsel[1] ? e_m[i] : e_n[i], rsel, aw);
                if (ws) begin
                    if (wsel[1]) e_m[i] = wr_model(e_m[i], wsel, din, aw);
                    else         e_n[i] = wr_model(e_n[i], wsel, din, aw);
                end
            end
            if (rs) rsel = rsel + 2'd1;
            if (ws) wsel = wsel + 2'd1;
        end
        @(negedge clk);
        check(req, "n10",   16'(n10),  e_n[0]);
        check(req, "m10",   16'(m10),  e_m[0]);
        check(req, "rd10",  16'(rd10), 16'(e_rd[0]));
        check(req, "col10", 16'(col10), 16'(e_col));
        check(req, "n8",    16'(n8),   e_n[1]);
        check(req, "m8",    16'(m8),   e_m[1]);
        check(req, "rd8",   16'(rd8),  16'(e_rd[1]));
        check(req, "col8",  16'(col8), 16'(e_col));
    endtask

    task automatic drive(input logic l, input logic w, input logic r1, input logic r2, input logic [8:0] d);
        ld_n = l; wen_n = w; ren1_n = r1; ren2_n = r2; din = d;
    endtask

    task automatic do_reset(input logic ld_level, input string req);
        rst_n = 1'b0;
        drive(ld_level, 1'b1, 1'b1, 1'b1, 9'h000);
        cycle(req);
        cycle(req);
        rst_n = 1'b1;
        drive(1'b1, 1'b1, 1'b1, 1'b1, 9'h000);
        cycle(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int unsigned r;
        void'($urandom(32'h5EED_0421));
        rst_n = 1'b0;
        drive(1'b0, 1'b1, 1'b1, 1'b1, 9'h000);

        // R1: reset state in load mode
        do_reset(1'b0, "R1");

        // R2: write all four slots, then the wrap to the first slot
        drive(1'b0, 1'b0, 1'b1, 1'b1, 9'h0A5); cycle("R2");
        drive(1'b0, 1'b0, 1'b1, 1'b1, 9'h1FF); cycle("R7");
        drive(1'b0, 1'b0, 1'b1, 1'b1, 9'h03C); cycle("R2");
        drive(1'b0, 1'b0, 1'b1, 1'b1, 9'h102); cycle("R2");
        drive(1'b0, 1'b0, 1'b1, 1'b1, 9'h011); cycle("R2");

        // R3: load low, write enable high
        drive(1'b0, 1'b1, 1'b1, 1'b1, 9'h0EE); cycle("R3");
        // R4: load high, write enable low, read enables low
        drive(1'b1, 1'b0, 1'b0, 1'b0, 9'h0DD); cycle("R4");
        // R5: partial burst continues at the next slot (n high part)
        drive(1'b0, 1'b0, 1'b1, 1'b1, 9'h001); cycle("R5");
        drive(1'b1, 1'b1, 1'b1, 1'b1, 9'h000); cycle("R5");
        drive(1'b0, 1'b0, 1'b1, 1'b1, 9'h077); cycle("R5");

        // R6, R7: read four slots plus wrap; one read enable high holds
        for (int k = 0; k < 5; k++) begin
            drive(1'b0, 1'b1, 1'b0, 1'b0, 9'h000); cycle("R6");
        end
        drive(1'b0, 1'b1, 1'b1, 1'b0, 9'h000); cycle("R6");
        drive(1'b0, 1'b1, 1'b0, 1'b1, 9'h000); cycle("R6");

        // R9: simultaneous read and write
        drive(1'b0, 1'b0, 1'b0, 1'b0, 9'h155); cycle("R9");
        drive(1'b0, 1'b1, 1'b1, 1'b1, 9'h000); cycle("R9");

        // constrained random traffic
        for (int k = 0; k < 600; k++) begin
            r = $urandom % 8;
            din = 9'($urandom);
            case (r)
                0, 1: begin drive(1'b0, 1'b0, 1'b1, 1'b1, din); cycle("R2"); end
                2, 3: begin drive(1'b0, 1'b1, 1'b0, 1'b0, din); cycle("R6"); end
                4:    begin drive(1'b0, 1'b1, 1'b1, 1'b1, din); cycle("R3"); end
                5:    begin drive(1'b1, 1'b0, 1'b0, 1'b0, din); cycle("R4"); end
                6:    begin drive(1'b0, 1'b0, 1'b0, 1'b0, din); cycle("R9"); end
                default: begin drive(1'b0, 1'b1, 1'($urandom), 1'b1, din); cycle("R6"); end
            endcase
        end

        // R8: enable mode after reset with load high
        do_reset(1'b1, "R8");
        for (int k = 0; k < 12; k++) begin
            drive(1'b0, 1'b0, 1'b0, 1'b0, 9'($urandom)); cycle("R8");
        end

        // R1: back to load mode, defaults restored
        do_reset(1'b0, "R1");
        drive(1'b0, 1'b1, 1'b0, 1'b0, 9'h000); cycle("R1");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule